// File: doc/BRIEF.md
# Auto-Incrementing Byte-Mapped Pointer Register

This block holds a 16-bit address pointer. The host CPU sees it as two byte-wide registers, a low byte and a high byte. Software loads the pointer with two ordinary byte stores, in the same way it would fill a pair of RAM bytes. Software reads it back the same way, one byte at a time.

After the pointer is loaded, an external sequencer advances it with one-cycle strobes. One strobe adds one to the full 16-bit value. The other adds two. Either way the pointer is updated in a single clock, so each step fits easily inside a two-cycle instruction slot.

A sequencer can also place either pointer byte on the CPU data bus through an override request. This path does not depend on the normal address decoding. It lets the pointer be used directly as the operand of an indirect jump or fetch.

Top module: `ptr_autoinc`

## Requirements
- R1: While `rst_n` is low, and on the first clock edge after it is released, `ptr_q` is 16'h0000.
- R2: A byte write with `wr_hi`=0 loads `wr_data` into bits [7:0] of the pointer at the next rising edge. Bits [15:8] are left unchanged.
- R3: A byte write with `wr_hi`=1 loads `wr_data` into bits [15:8] at the next rising edge. Bits [7:0] are left unchanged.
- R4: With `inc_one` high and no write, the pointer becomes (value + 1) mod 65536 at the next edge. The carry runs from the low byte into the high byte, and FFFFh wraps to 0000h.
- R5: With `inc_two` high and no write, the pointer becomes (value + 2) mod 65536 at the next edge, in one clock. FFFEh goes to 0000h and FFFFh goes to 0001h.
- R6: When `wr_en` is high in the same cycle as any increment strobe, only the write takes effect. No increment is applied to either byte.
- R7: When `inc_one` and `inc_two` are both high without a write, the step is +2.
- R8: `rd_data` shows, in the same cycle, the low byte of the current pointer when `rd_hi`=0 and the high byte when `rd_hi`=1.
- R9: `bus_oe` equals `ovr_en` in the same cycle. While `ovr_en` is high, `bus_data` carries the byte chosen by `ovr_hi` (0 = low, 1 = high). While `ovr_en` is low, `bus_data` is 8'h00.
- R10: With no write and no strobe, the pointer holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_hi | input | 1 | Write byte select: 0 = low, 1 = high |
| wr_data | input | 8 | Byte to write |
| rd_hi | input | 1 | Read byte select: 0 = low, 1 = high |
| rd_data | output | 8 | Selected pointer byte |
| inc_one | input | 1 | Advance the pointer by 1 |
| inc_two | input | 1 | Advance the pointer by 2 |
| ovr_en | input | 1 | Override request to drive the data bus |
| ovr_hi | input | 1 | Override byte select: 0 = low, 1 = high |
| bus_oe | output | 1 | Data bus drive enable |
| bus_data | output | 8 | Byte driven onto the data bus |
| ptr_q | output | 16 | Full current pointer value |

## Verification
A wrong stored value shows at `ptr_q` one edge after the command that caused it. It shows on `rd_data` and `bus_data` in the same cycle the pointer is observed, because both are purely combinational selects of the register.

A carry that is lost between the bytes shows only when the low byte crosses FFh. A +2 step that is split into two +1 steps, or a lost write priority, shows as a value that is off by one or two after a single edge. For these reasons the stimulus aims directly at the byte boundaries and the wrap points, and the value is compared after every edge.

// File: rtl/ptr_autoinc.sv
module ptr_autoinc #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_hi,
  input  logic [BW-1:0] wr_data,
  input  logic          rd_hi,
  output logic [BW-1:0] rd_data,
  input  logic          inc_one,
  input  logic          inc_two,
  input  logic          ovr_en,
  input  logic          ovr_hi,
  output logic          bus_oe,
  output logic [BW-1:0] bus_data,
  output logic [2*BW-1:0] ptr_q
);
  localparam int PW = 2 * BW;

  logic [PW-1:0] ptr;
  logic [PW-1:0] step;
  logic          armed;

  assign step = inc_two ? PW'(2) : (inc_one ? PW'(1) : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr   <= '0;
      armed <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (wr_en) begin
        if (wr_hi) ptr[PW-1:BW] <= wr_data;
        else       ptr[BW-1:0]  <= wr_data;
      end else begin
        ptr <= ptr + step;
      end
    end
  end

  assign ptr_q    = ptr;
  assign rd_data  = rd_hi ? ptr[PW-1:BW] : ptr[BW-1:0];
  assign bus_oe   = ovr_en;
  assign bus_data = ovr_en ? (ovr_hi ? ptr[PW-1:BW] : ptr[BW-1:0]) : '0;

  p_reset_r1: assert property (@(posedge clk) !rst_n |=> ptr_q == '0);

  p_wr_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed && wr_en && !wr_hi |=>
      ptr_q[BW-1:0] == $past(wr_data) && ptr_q[PW-1:BW] == $past(ptr_q[PW-1:BW]));

  p_wr_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    armed && wr_en && wr_hi |=>
      ptr_q[PW-1:BW] == $past(wr_data) && ptr_q[BW-1:0] == $past(ptr_q[BW-1:0]));

  p_inc1_r4: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !wr_en && inc_one && !inc_two |=> ptr_q == PW'($past(ptr_q) + 1));

  p_inc2_r5_r7: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !wr_en && inc_two |=> ptr_q == PW'($past(ptr_q) + 2));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !wr_en && !inc_one && !inc_two |=> $stable(ptr_q));

  always_comb begin
    if (rst_n) begin
      p_read_r8: assert (rd_data == (rd_hi ? ptr_q[PW-1:BW] : ptr_q[BW-1:0]));
      p_ovr_r9:  assert (bus_oe == ovr_en && (ovr_en || bus_data == '0));
    end
  end
endmodule

// File: tb/sim_ptr_autoinc.sv
module sim_ptr_autoinc;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_hi = 1'b0, rd_hi = 1'b0;
  logic inc_one = 1'b0, inc_two = 1'b0, ovr_en = 1'b0, ovr_hi = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data, bus_data;
  logic bus_oe;
  logic [15:0] ptr_q;
  logic [15:0] model;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  ptr_autoinc u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_hi), .wr_data(wr_data),
    .rd_hi(rd_hi), .rd_data(rd_data), .inc_one(inc_one), .inc_two(inc_two),
    .ovr_en(ovr_en), .ovr_hi(ovr_hi), .bus_oe(bus_oe), .bus_data(bus_data),
    .ptr_q(ptr_q));

  function automatic logic [15:0] nxt(input logic [15:0] c, input logic we, input logic hi,
                                      input logic [7:0] d, input logic i1, input logic i2);
    if (we) return hi ? {d, c[7:0]} : {c[15:8], d};
    if (i2) return c + 16'd2;
    if (i1) return c + 16'd1;
    return c;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic hi, input logic [7:0] d,
                     input logic i1, input logic i2, input string req);
    @(negedge clk);
    wr_en = we; wr_hi = hi; wr_data = d; inc_one = i1; inc_two = i2;
    @(posedge clk);
    model = nxt(model, we, hi, d, i1, i2);
    @(negedge clk);
    wr_en = 0; inc_one = 0; inc_two = 0;
    chk(req, ptr_q, model);
  endtask

  task automatic load(input logic [15:0] v);
    cyc(1, 0, v[7:0], 0, 0, "R2");
    cyc(1, 1, v[15:8], 0, 0, "R3");
  endtask

  task automatic look(input logic rh, input logic oe, input logic oh);
    rd_hi = rh; ovr_en = oe; ovr_hi = oh;
    #1;
    chk("R8", {8'h00, rd_data}, {8'h00, rh ? model[15:8] : model[7:0]});
    chk("R9", {7'h0, bus_oe, bus_data},
        {7'h0, oe, oe ? (oh ? model[15:8] : model[7:0]) : 8'h00});
  endtask

  initial begin
    #20000000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    model = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", ptr_q, 16'h0000);
    rst_n = 1;
    load(16'h12ff);
    cyc(0, 0, 0, 1, 0, "R4 carry");
    chk("R4", ptr_q, 16'h1300);
    load(16'hffff);
    cyc(0, 0, 0, 1, 0, "R4 wrap");
    chk("R4", ptr_q, 16'h0000);
    load(16'hffff);
    cyc(0, 0, 0, 0, 1, "R5 wrap");
    chk("R5", ptr_q, 16'h0001);
    load(16'hfffe);
    cyc(0, 0, 0, 0, 1, "R5");
    chk("R5", ptr_q, 16'h0000);
    load(16'h00ff);
    cyc(0, 0, 0, 0, 1, "R5 carry");
    chk("R5", ptr_q, 16'h0101);
    cyc(1, 0, 8'h55, 1, 1, "R6 lo");
    chk("R6", ptr_q, 16'h0155);
    cyc(1, 1, 8'haa, 0, 1, "R6 hi");
    chk("R6", ptr_q, 16'haa55);
    cyc(0, 0, 0, 1, 1, "R7");
    chk("R7", ptr_q, 16'haa57);
    cyc(0, 0, 0, 0, 0, "R10");
    chk("R10", ptr_q, 16'haa57);
    look(0, 0, 0);
    look(1, 1, 1);
    look(0, 1, 0);
    for (int i = 0; i < 400; i++) begin
      logic [3:0] r;
      r = 4'($urandom);
      cyc(r[3] & r[2], r[1], 8'($urandom), r[0], r[1] & ~r[2], "R2/R3/R4/R5/R6/R10 random");
      look(1'($urandom), 1'($urandom), 1'($urandom));
    end
    rst_n = 0;
    @(posedge clk);
    model = '0;
    @(negedge clk);
    chk("R1", ptr_q, 16'h0000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule